// File: doc/BRIEF.md
# Deferred Cache-Line Invalidate Queue

This block sits beside one core's private cache tags. Other agents send it requests to invalidate a cache line. Each request enters an in-order queue, and the requester is acknowledged as soon as the entry is stored. The valid bit in the local tag array is cleared later, when the entry reaches the head of the queue. Until that happens, the local core keeps issuing lookups. A lookup to a line that is still queued for invalidation returns the old, stale hit, and a debug flag shows that an invalidate for that line is pending.

The small direct-mapped tag array holds a valid bit, a dirty bit and a tag for each set. Lines are installed through a fill port. A clean request on a dirty line raises a write-back request and holds it until the write-back completes, and only then clears the dirty bit. While that write-back is outstanding, the queue does not apply an invalidate of the same line.

Two barrier handshakes let the core wait on the queue:

- **Full-completion barrier.** It completes only once the queue is empty.
- **Ordering barrier.** It completes once the entries that were queued when it was raised have been applied. Entries queued after it may still be pending.

Each barrier runs a small state machine:

- `B_IDLE` moves to `B_WAIT` when the request is raised.
- `B_WAIT` moves to `B_DONE` when its completion condition is met.
- `B_DONE` moves back to `B_IDLE` when the request is dropped.

The clean engine has two states:

- `C_IDLE` moves to `C_WB` when a clean hits a dirty line.
- `C_WB` moves back to `C_IDLE` when the write-back completes.

Top module: `inval_defer_queue`

## Requirements
- R1: After reset the queue is empty, `inv_ready` is 1, and `inv_ack`, `wb_req`, both barrier dones, `lk_hit`, `lk_dirty` and `lk_pend` are 0. `cln_ready` is 1, and every line address misses on lookup.
- R2: An invalidate is accepted on a clock edge where `inv_valid` and `inv_ready` are both 1. `inv_ack` is 1 for the one cycle after that edge, before the line is necessarily cleared.
- R3: When DEPTH entries are queued, `inv_ready` is 0. A request presented then is not accepted and produces no acknowledge.
- R4: The queue applies at most one entry per edge, in arrival order. Applying an entry whose tag matches a valid line clears that line, so later lookups miss.
- R5: A lookup to a line with a queued but unapplied invalidate still reports a hit on the old copy, with `lk_pend` 1. Lookup results appear in the cycle after `lk_valid` is sampled.
- R6: An invalidate whose tag does not match the line in its set, or whose set is empty, leaves the array unchanged but still leaves the queue in order.
- R7: `bar_full_done` rises only on the edge at which the queue becomes, or already is, empty. A request raised on an empty queue sees done one edge after the edge that first samples it.
- R8: `bar_ord_done` rises once every entry queued up to and including the edge that sampled the request has been applied. It does not wait for later-queued entries.
- R9: A clean on a valid dirty line drives `wb_req` 1 with a stable `wb_addr` until `wb_done`, then clears the dirty bit and keeps the line valid. A clean on a clean or absent line raises no `wb_req`.
- R10: While `wb_req` is 1, an invalidate at the head of the queue for the same line address is not applied.
- R11: A fill installs its line as valid, with its tag and the dirty value given, replacing whatever the set held. The lookup outputs report it.
- R12: A barrier's done stays 1 while its request stays 1, and returns to 0 one edge after the request is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_valid | input | 1 | Invalidate request present |
| inv_addr | input | LINE_AW | Line address to invalidate |
| inv_ready | output | 1 | Queue can accept a request |
| inv_ack | output | 1 | One-cycle acknowledge of an accepted request |
| lk_valid | input | 1 | Local lookup strobe |
| lk_addr | input | LINE_AW | Lookup line address |
| lk_hit | output | 1 | Lookup hit (registered) |
| lk_dirty | output | 1 | Hit line is dirty (registered) |
| lk_pend | output | 1 | Debug: matching invalidate still queued (registered) |
| fill_valid | input | 1 | Install a line |
| fill_addr | input | LINE_AW | Line address being installed |
| fill_dirty | input | 1 | Dirty value for the installed line |
| cln_valid | input | 1 | Clean request |
| cln_addr | input | LINE_AW | Line address to clean |
| cln_ready | output | 1 | Clean engine idle |
| wb_req | output | 1 | Write-back request outstanding |
| wb_addr | output | LINE_AW | Write-back line address |
| wb_done | input | 1 | Write-back completed |
| bar_full_req | input | 1 | Full-completion barrier request |
| bar_full_done | output | 1 | Full-completion barrier satisfied |
| bar_ord_req | input | 1 | Ordering barrier request |
| bar_ord_done | output | 1 | Ordering barrier satisfied |

## Verification
The bench builds the block with LINE_AW=5, INDEX_W=3 and DEPTH=4. That gives eight sets, four tags per set and thirty-two line addresses in all, so the fill/lookup/invalidate sweep visits every address together with its tag alias in the same set. A DEPTH of four lets the queue be filled completely behind a stalled head in a few cycles, which brings the full-queue back-pressure, the stale-hit window and the exact drain-to-barrier cycle counts within reach of direct arithmetic checks.

// File: rtl/inval_pkg.sv
package inval_pkg;

    typedef enum logic [1:0] {
        B_IDLE = 2'd0,
        B_WAIT = 2'd1,
        B_DONE = 2'd2
    } bar_state_t;

    typedef enum logic {
        C_IDLE = 1'b0,
        C_WB   = 1'b1
    } cln_state_t;

endpackage

// File: rtl/inv_fifo.sv
module inv_fifo #(
    parameter int DEPTH = 8,
    parameter int AW    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [AW-1:0]                 push_addr,
    input  logic                          pop,
    output logic [AW-1:0]                 head_addr,
    output logic                          empty,
    output logic                          full,
    output logic [$clog2(DEPTH+1)-1:0]    count_next,
    input  logic [AW-1:0]                 probe_addr,
    output logic                          probe_hit
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [AW-1:0]    mem [DEPTH];
    logic [DEPTH-1:0] occ;
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic [DEPTH-1:0] hitv;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty      = (count == '0);
    assign full       = (count == CNT_W'(DEPTH));
    assign head_addr  = mem[rd_ptr];
    assign count_next = count + CNT_W'(push) - CNT_W'(pop);

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_probe
            assign hitv[i] = occ[i] && (mem[i] == probe_addr);
        end
    endgenerate
    assign probe_hit = |hitv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
            occ    <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_ptr] <= push_addr;
                occ[wr_ptr] <= 1'b1;
                wr_ptr      <= ptr_inc(wr_ptr);
            end
            if (pop) begin
                occ[rd_ptr] <= 1'b0;
                rd_ptr      <= ptr_inc(rd_ptr);
            end
            count <= count_next;
        end
    end

    // R3: the queue never takes an entry while it is full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4: occupancy falls by at most one per edge
    p_one_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(count) + 1) >= int'($past(count)));

    // R4: the pop strobe is never given for an empty queue
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/tag_array.sv
module tag_array #(
    parameter int AW      = 16,
    parameter int INDEX_W = 6,
    parameter int NRD     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NRD-1:0][AW-1:0]    rd_addr,
    output logic [NRD-1:0]            rd_hit,
    output logic [NRD-1:0]            rd_dirty,
    input  logic                      fill_en,
    input  logic [AW-1:0]             fill_addr,
    input  logic                      fill_dirty,
    input  logic                      inv_en,
    input  logic [AW-1:0]             inv_addr,
    input  logic                      cdone_en,
    input  logic [AW-1:0]             cdone_addr
);
    localparam int SETS  = 1 << INDEX_W;
    localparam int TAG_W = AW - INDEX_W;

    logic [TAG_W-1:0] tags [SETS];
    logic [SETS-1:0]  vld;
    logic [SETS-1:0]  drt;

    generate
        for (genvar r = 0; r < NRD; r++) begin : g_rd
            logic [INDEX_W-1:0] idx;
            assign idx         = rd_addr[r][INDEX_W-1:0];
            assign rd_hit[r]   = vld[idx] && (tags[idx] == rd_addr[r][AW-1:INDEX_W]);
            assign rd_dirty[r] = rd_hit[r] && drt[idx];
        end
    endgenerate

    logic [INDEX_W-1:0] f_idx, i_idx, c_idx;
    assign f_idx = fill_addr[INDEX_W-1:0];
    assign i_idx = inv_addr[INDEX_W-1:0];
    assign c_idx = cdone_addr[INDEX_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld <= '0;
            drt <= '0;
            for (int s = 0; s < SETS; s++) tags[s] <= '0;
        end else begin
            if (cdone_en && vld[c_idx] && (tags[c_idx] == cdone_addr[AW-1:INDEX_W]))
                drt[c_idx] <= 1'b0;
            if (inv_en && vld[i_idx] && (tags[i_idx] == inv_addr[AW-1:INDEX_W])) begin
                vld[i_idx] <= 1'b0;
                drt[i_idx] <= 1'b0;
            end
            if (fill_en) begin
                vld[f_idx]  <= 1'b1;
                drt[f_idx]  <= fill_dirty;
                tags[f_idx] <= fill_addr[AW-1:INDEX_W];
            end
        end
    end

    // R11: a dirty bit only ever sits on a valid line
    generate
        for (genvar s = 0; s < SETS; s++) begin : g_inv
            p_dirty_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
                drt[s] |-> vld[s]);
        end
    endgenerate

endmodule

// File: rtl/bar_fsm.sv
module bar_fsm
    import inval_pkg::*;
#(
    parameter int DEPTH      = 8,
    parameter bit ORDER_ONLY = 1'b0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req,
    input  logic [$clog2(DEPTH+1)-1:0]    q_count_next,
    input  logic                          pop,
    output logic                          done
);
    localparam int CNT_W = $clog2(DEPTH+1);

    bar_state_t       state, state_nx;
    logic [CNT_W-1:0] left;
    logic             met;

    // completion condition depends on the barrier flavour
    generate
        if (ORDER_ONLY) begin : g_ord
            assign met = (left == '0) || ((left == CNT_W'(1)) && pop);
        end else begin : g_full
            assign met = (q_count_next == '0);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= B_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left <= '0;
        end else if (state == B_IDLE && req) begin
            left <= q_count_next;
        end else if (state == B_WAIT && pop && left != '0) begin
            left <= left - CNT_W'(1);
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            B_IDLE:  if (req)  state_nx = B_WAIT;
            B_WAIT:  if (met)  state_nx = B_DONE;
            B_DONE:  if (!req) state_nx = B_IDLE;
            default: state_nx = B_IDLE;
        endcase
    end

    always_comb begin
        done = (state == B_DONE);
    end

    generate
        if (ORDER_ONLY) begin : g_a_ord
            // R8: done rises only when at most one earlier entry was left
            p_ord_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done) |-> ($past(left) <= CNT_W'(1)));
        end else begin : g_a_full
            // R7: done rises only when the queue emptied on that edge
            p_full_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(done) |-> ($past(q_count_next) == '0));
        end
    endgenerate

    // R12: done is held while the request is held
    p_done_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && req) |=> done);

endmodule

// File: rtl/clean_fsm.sv
module clean_fsm
    import inval_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cln_valid,
    input  logic [AW-1:0] cln_addr,
    input  logic          line_hit,
    input  logic          line_dirty,
    input  logic          wb_done,
    output logic          cln_ready,
    output logic          wb_req,
    output logic [AW-1:0] wb_addr,
    output logic          cdone_en
);
    cln_state_t    state, state_nx;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                              addr_q <= '0;
        else if (state == C_IDLE && cln_valid && line_dirty)     addr_q <= cln_addr;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            C_IDLE:  if (cln_valid && line_hit && line_dirty) state_nx = C_WB;
            C_WB:    if (wb_done)                            state_nx = C_IDLE;
            default: state_nx = C_IDLE;
        endcase
    end

    always_comb begin
        cln_ready = (state == C_IDLE);
        wb_req    = (state == C_WB);
        wb_addr   = addr_q;
        cdone_en  = (state == C_WB) && wb_done;
    end

    // R9: the write-back request and its address hold until completion
    p_wb_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_done) |=> (wb_req && $stable(wb_addr)));

endmodule

// File: rtl/inval_defer_queue.sv
module inval_defer_queue
    import inval_pkg::*;
#(
    parameter int LINE_AW = 16,
    parameter int INDEX_W = 6,
    parameter int DEPTH   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_valid,
    input  logic [LINE_AW-1:0] inv_addr,
    output logic               inv_ready,
    output logic               inv_ack,
    input  logic               lk_valid,
    input  logic [LINE_AW-1:0] lk_addr,
    output logic               lk_hit,
    output logic               lk_dirty,
    output logic               lk_pend,
    input  logic               fill_valid,
    input  logic [LINE_AW-1:0] fill_addr,
    input  logic               fill_dirty,
    input  logic               cln_valid,
    input  logic [LINE_AW-1:0] cln_addr,
    output logic               cln_ready,
    output logic               wb_req,
    output logic [LINE_AW-1:0] wb_addr,
    input  logic               wb_done,
    input  logic               bar_full_req,
    output logic               bar_full_done,
    input  logic               bar_ord_req,
    output logic               bar_ord_done
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int NRD   = 2;

    logic               q_push, q_pop, q_empty, q_full, q_probe_hit;
    logic [LINE_AW-1:0] q_head;
    logic [CNT_W-1:0]   q_count_next;
    logic               head_stall;
    logic               cdone_en;

    logic [NRD-1:0][LINE_AW-1:0] rd_addr;
    logic [NRD-1:0]              rd_hit, rd_dirty;

    assign inv_ready = !q_full;
    assign q_push    = inv_valid && !q_full;

    // head waits on a same-line write-back or a same-set fill
    assign head_stall = (wb_req && (q_head == wb_addr)) ||
                        (fill_valid && (q_head[INDEX_W-1:0] == fill_addr[INDEX_W-1:0]));
    assign q_pop      = !q_empty && !head_stall;

    assign rd_addr[0] = lk_addr;
    assign rd_addr[1] = cln_addr;

    inv_fifo #(.DEPTH(DEPTH), .AW(LINE_AW)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (q_push),
        .push_addr  (inv_addr),
        .pop        (q_pop),
        .head_addr  (q_head),
        .empty      (q_empty),
        .full       (q_full),
        .count_next (q_count_next),
        .probe_addr (lk_addr),
        .probe_hit  (q_probe_hit)
    );

    tag_array #(.AW(LINE_AW), .INDEX_W(INDEX_W), .NRD(NRD)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_addr    (rd_addr),
        .rd_hit     (rd_hit),
        .rd_dirty   (rd_dirty),
        .fill_en    (fill_valid),
        .fill_addr  (fill_addr),
        .fill_dirty (fill_dirty),
        .inv_en     (q_pop),
        .inv_addr   (q_head),
        .cdone_en   (cdone_en),
        .cdone_addr (wb_addr)
    );

    clean_fsm #(.AW(LINE_AW)) u_clean (
        .clk        (clk),
        .rst_n      (rst_n),
        .cln_valid  (cln_valid),
        .cln_addr   (cln_addr),
        .line_hit   (rd_hit[1]),
        .line_dirty (rd_dirty[1]),
        .wb_done    (wb_done),
        .cln_ready  (cln_ready),
        .wb_req     (wb_req),
        .wb_addr    (wb_addr),
        .cdone_en   (cdone_en)
    );

    bar_fsm #(.DEPTH(DEPTH), .ORDER_ONLY(1'b0)) u_bar_full (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (bar_full_req),
        .q_count_next (q_count_next),
        .pop          (q_pop),
        .done         (bar_full_done)
    );

    bar_fsm #(.DEPTH(DEPTH), .ORDER_ONLY(1'b1)) u_bar_ord (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (bar_ord_req),
        .q_count_next (q_count_next),
        .pop          (q_pop),
        .done         (bar_ord_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inv_ack  <= 1'b0;
            lk_hit   <= 1'b0;
            lk_dirty <= 1'b0;
            lk_pend  <= 1'b0;
        end else begin
            inv_ack  <= q_push;
            lk_hit   <= lk_valid && rd_hit[0];
            lk_dirty <= lk_valid && rd_dirty[0];
            lk_pend  <= lk_valid && q_probe_hit;
        end
    end

    // R2: an acknowledge is only seen with the entry held in the queue
    p_ack_queued_r2: assert property (@(posedge clk) disable iff (!rst_n)
        inv_ack |-> !q_empty);

    // R3: a full queue refuses requests
    p_full_refuse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !inv_ready);

    // R10: a head matching the outstanding write-back is held in place
    p_wb_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !q_empty && (q_head == wb_addr)) |=> (q_head == $past(q_head)) && !q_empty);

    // R5: a pending-invalidate flag only accompanies a lookup
    p_pend_lookup_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pend |-> $past(lk_valid));

endmodule

// File: tb/inval_defer_queue_bench.sv
module inval_defer_queue_bench;
    localparam int LAW = 5;
    localparam int IW  = 3;
    localparam int DP  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inv_valid = 0, lk_valid = 0, fill_valid = 0, fill_dirty = 0;
    logic cln_valid = 0, wb_done = 0, bar_full_req = 0, bar_ord_req = 0;
    logic [LAW-1:0] inv_addr = '0, lk_addr = '0, fill_addr = '0, cln_addr = '0;
    logic inv_ready, inv_ack, lk_hit, lk_dirty, lk_pend, cln_ready, wb_req;
    logic bar_full_done, bar_ord_done;
    logic [LAW-1:0] wb_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    inval_defer_queue #(.LINE_AW(LAW), .INDEX_W(IW), .DEPTH(DP)) u_inval_defer_queue (
        .clk(clk), .rst_n(rst_n),
        .inv_valid(inv_valid), .inv_addr(inv_addr), .inv_ready(inv_ready), .inv_ack(inv_ack),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_dirty(lk_dirty), .lk_pend(lk_pend),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_dirty(fill_dirty),
        .cln_valid(cln_valid), .cln_addr(cln_addr), .cln_ready(cln_ready),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_done(wb_done),
        .bar_full_req(bar_full_req), .bar_full_done(bar_full_done),
        .bar_ord_req(bar_ord_req), .bar_ord_done(bar_ord_done)
    );

    task automatic check(input string rq, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_fill(input logic [LAW-1:0] a, input logic d);
        fill_valid = 1; fill_addr = a; fill_dirty = d;
        cyc();
        fill_valid = 0;
    endtask

    task automatic do_look(input logic [LAW-1:0] a, output logic h, output logic d, output logic p);
        lk_valid = 1; lk_addr = a;
        cyc();
        h = lk_hit; d = lk_dirty; p = lk_pend;
        lk_valid = 0;
    endtask

    task automatic do_push(input logic [LAW-1:0] a, output logic ack);
        inv_valid = 1; inv_addr = a;
        cyc();
        ack = inv_ack;
        inv_valid = 0;
    endtask

    task automatic do_clean(input logic [LAW-1:0] a);
        cln_valid = 1; cln_addr = a;
        cyc();
        cln_valid = 0;
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL R4 watchdog expired actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic h, d, p, ack;
        logic [LAW-1:0] x, y, z, x2, al;
        int j;

        repeat (3) cyc();
        rst_n = 1;
        cyc();

        // R1: reset state
        check("R1 inv_ready", int'(inv_ready), 1);
        check("R1 inv_ack", int'(inv_ack), 0);
        check("R1 wb_req", int'(wb_req), 0);
        check("R1 cln_ready", int'(cln_ready), 1);
        check("R1 full_done", int'(bar_full_done), 0);
        check("R1 ord_done", int'(bar_ord_done), 0);
        check("R1 lk_hit idle", int'(lk_hit), 0);
        check("R1 lk_pend idle", int'(lk_pend), 0);
        for (int a = 0; a < (1 << LAW); a++) begin
            do_look(LAW'(a), h, d, p);
            check("R1 miss after reset", int'(h), 0);
        end

        // R11 R2 R6 R4: sweep every line address with its tag alias
        for (int a = 0; a < (1 << LAW); a++) begin
            x  = LAW'(a);
            al = x ^ LAW'(1 << IW);
            do_fill(x, x[0]);
            do_look(x, h, d, p);
            check("R11 fill hit", int'(h), 1);
            check("R11 fill dirty", int'(d), int'(x[0]));
            do_look(al, h, d, p);
            check("R11 alias miss", int'(h), 0);
            do_push(al, ack);
            check("R2 ack alias", int'(ack), 1);
            cyc();
            do_look(x, h, d, p);
            check("R6 mismatch no-op hit", int'(h), 1);
            check("R6 mismatch not pending", int'(p), 0);
            do_push(x, ack);
            check("R2 ack line", int'(ack), 1);
            cyc();
            do_look(x, h, d, p);
            check("R4 applied miss", int'(h), 0);
        end

        // R9: clean on a clean line raises nothing
        y = 5'd9;
        do_fill(y, 1'b0);
        do_clean(y);
        check("R9 clean line no wb", int'(wb_req), 0);
        check("R9 clean line ready", int'(cln_ready), 1);
        // R9: clean on a dirty line
        do_fill(y, 1'b1);
        do_clean(y);
        check("R9 wb_req", int'(wb_req), 1);
        check("R9 wb_addr", int'(wb_addr), int'(y));
        check("R9 busy", int'(cln_ready), 0);
        cyc(); cyc();
        check("R9 wb held", int'(wb_req), 1);
        wb_done = 1; cyc(); wb_done = 0;
        check("R9 wb released", int'(wb_req), 0);
        do_look(y, h, d, p);
        check("R9 still valid", int'(h), 1);
        check("R9 dirty cleared", int'(d), 0);

        // R10 R3 R5 R7 R4 R12: stall head behind a write-back, fill queue
        x = 5'd5;
        do_fill(x, 1'b1);
        do_clean(x);
        check("R9 wb_req x", int'(wb_req), 1);
        for (int i = 0; i < DP; i++) begin
            do_push(x, ack);
            check("R2 ack fill queue", int'(ack), 1);
        end
        check("R3 ready low when full", int'(inv_ready), 0);
        do_push(5'd1, ack);
        check("R3 no ack when full", int'(ack), 0);
        do_look(x, h, d, p);
        check("R5 stale hit", int'(h), 1);
        check("R5 pending flag", int'(p), 1);
        check("R10 head held", int'(inv_ready), 0);
        do_look(x ^ LAW'(1 << IW), h, d, p);
        check("R5 alias not pending", int'(p), 0);
        bar_full_req = 1;
        cyc(); cyc(); cyc();
        check("R7 done waits on queue", int'(bar_full_done), 0);
        wb_done = 1; cyc(); wb_done = 0;
        j = 0;
        while (!bar_full_done && j < 40) begin
            cyc(); j++;
        end
        check("R4 R7 drain cycles to done", j, DP);
        cyc();
        check("R12 done held", int'(bar_full_done), 1);
        bar_full_req = 0;
        cyc();
        check("R12 done dropped", int'(bar_full_done), 0);
        do_look(x, h, d, p);
        check("R4 line cleared", int'(h), 0);
        check("R4 nothing pending", int'(p), 0);

        // R7: empty queue barrier
        bar_full_req = 1;
        cyc();
        check("R7 empty first edge", int'(bar_full_done), 0);
        cyc();
        check("R7 empty next edge", int'(bar_full_done), 1);
        bar_full_req = 0; cyc();
        check("R12 full release", int'(bar_full_done), 0);

        // R8: empty queue ordering barrier
        bar_ord_req = 1;
        cyc();
        check("R8 empty first edge", int'(bar_ord_done), 0);
        cyc();
        check("R8 empty next edge", int'(bar_ord_done), 1);
        bar_ord_req = 0; cyc();
        check("R12 ord release", int'(bar_ord_done), 0);

        // R8: ordering barrier ignores later entries
        x2 = 5'd3;
        z  = 5'd12;
        do_fill(x2, 1'b1);
        do_fill(z, 1'b0);
        do_clean(x2);
        do_push(x2, ack);
        do_push(x2, ack);
        bar_ord_req = 1;
        cyc();
        do_push(z, ack);
        check("R2 ack later entry", int'(ack), 1);
        cyc(); cyc();
        check("R8 waits on earlier", int'(bar_ord_done), 0);
        wb_done = 1; cyc(); wb_done = 0;
        j = 0;
        while (!bar_ord_done && j < 40) begin
            cyc(); j++;
        end
        check("R8 cycles to done", j, 2);
        do_look(z, h, d, p);
        check("R8 later still stale hit", int'(h), 1);
        check("R8 later still pending", int'(p), 1);
        bar_ord_req = 0;
        cyc();
        check("R12 ord dropped", int'(bar_ord_done), 0);
        do_look(z, h, d, p);
        check("R4 later applied", int'(h), 0);
        do_look(x2, h, d, p);
        check("R4 earlier applied", int'(h), 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule